// File: doc/BRIEF.md
# Length-Checked Serial Command Decoder

This block is the receive side of a slave serial port made of an active-low select, a serial clock and a data line. While select is low it shifts in data bits, most significant bit first, and counts them. When select is released it looks only at that count. A frame of exactly 8 bits becomes an indirect data byte. A frame of 16 bits becomes a register access. A frame of 24 bits becomes a direct display-memory byte access. Any other length is dropped and leaves no trace. The serial pins are brought into the system clock domain through a synchronizer. Serial edges are found by comparing successive synchronized samples, so the serial clock must stay well below the system clock.

Decoded commands leave through a one-entry valid/ready output. A command stays on the outputs, unchanged, until a cycle in which `cmd_valid` and `cmd_ready` are both high. While the slot is still full, a newly completed frame has no slot to go to and is discarded. The block also keeps the shared target-address register that every chip on the bus updates in step. A global register write to index 8 loads it. The auto-increment bit of any accepted 16-bit frame then steps it by one. A local register access is passed on only when that register equals this chip's own identity `self_id`.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After reset `cmd_valid` is 0 and `target_addr` is 0.
- R2: A frame is acted on only if exactly 8, 16 or 24 serial clock rises occur while select is low. Any other count gives no command and leaves `target_addr` unchanged. The count saturates, so frames longer than 24 bits are rejected.
- R3: Data is sampled on serial clock rising edges while select is low, and the first bit received is the most significant bit of the frame.
- R4: A 24-bit frame gives `cmd_kind` = 2 (memory). Its bit 23 is `cmd_read`. Bit 22 is ignored. Bits 21:8 are `cmd_addr`, and bits 7:0 are `cmd_data`.
- R5: A 16-bit frame gives `cmd_kind` = 1 (register). Its fields are: bit 15 read, bit 14 auto-increment, bit 13 global (1) or local (0), and bit 12 reserved. Bits 11:8 are the register index, placed in `cmd_addr[3:0]` with the rest of `cmd_addr` at 0. Bits 7:0 are data. If bit 12 is 1, the whole frame is ignored: there is no command and no target change.
- R6: A local 16-bit access gives a command only when `target_addr` equals `self_id`. A global one always gives a command, with `cmd_global` = 1.
- R7: A global write (bit 15 = 0) to register index 8 loads `target_addr` with the data byte.
- R8: An accepted 16-bit frame with bit 14 set adds one to `target_addr`, wrapping at 8 bits. This happens even if no command is emitted and even for reads, and it is applied after any load from R7.
- R9: An 8-bit frame gives `cmd_kind` = 0 (indirect), with the byte in `cmd_data` and `cmd_addr` = 0.
- R10: While `cmd_valid` is high and `cmd_ready` is low, all command outputs stay stable. A frame that completes in that state is discarded, but its effect on `target_addr` still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data |
| self_id | input | 8 | This chip's identity for local accesses |
| cmd_valid | output | 1 | Command slot holds a command |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_kind | output | 2 | 0 indirect, 1 register, 2 memory |
| cmd_read | output | 1 | Read (1) or write (0) |
| cmd_global | output | 1 | Global register access |
| cmd_addr | output | 14 | Memory address or register index |
| cmd_data | output | 8 | Data byte |
| target_addr | output | 8 | Shared target-address register |

## Verification
The bench sends frames of every accepted length with distinct bit patterns. Varying the read bit, the ignored bit and the address bits of the 24-bit frame shows that the fields are split in the right place and taken in the right order. Lengths one short of, one over and well past the accepted values (7, 9, 17 and 30) show that the count is exact and that it saturates. Register frames are sent with this chip's identity both matching and not matching the target, with the reserved bit set, and with loads and increments at the 8-bit wrap. Together these separate the emit decision from the target-register update. A final pattern leaves the output slot occupied while the next frame arrives, to check hold and drop under back-pressure.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  typedef enum logic [1:0] {
    CMD_INDIRECT = 2'd0,
    CMD_REGISTER = 2'd1,
    CMD_MEMORY   = 2'd2
  } cmd_kind_e;

  localparam int unsigned LEN_BYTE = 8;
  localparam int unsigned LEN_REG  = 16;
  localparam int unsigned LEN_MEM  = 24;
  localparam logic [3:0]  TARGET_REG_INDEX = 4'd8;
endpackage

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_BITS    = 24,
  localparam int unsigned CNT_SAT    = MAX_BITS + 1,
  localparam int unsigned CNT_W      = $clog2(CNT_SAT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n_i,
  input  logic                sclk_i,
  input  logic                din_i,
  output logic                frame_end,
  output logic [CNT_W-1:0]    frame_len,
  output logic [MAX_BITS-1:0] frame_bits
);
  localparam int unsigned SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SS-1:0] sel_q, clk_q, din_q;
  logic          sel_d, clk_d;
  logic          sel_s, clk_s, din_s;
  logic          bit_rise, sel_fall, sel_rise;
  logic [CNT_W-1:0] cnt_q;
  logic [MAX_BITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '1;
      clk_q <= '0;
      din_q <= '0;
      sel_d <= 1'b1;
      clk_d <= 1'b0;
    end else begin
      sel_q <= {sel_q[SS-2:0], sel_n_i};
      clk_q <= {clk_q[SS-2:0], sclk_i};
      din_q <= {din_q[SS-2:0], din_i};
      sel_d <= sel_s;
      clk_d <= clk_s;
    end
  end

  assign sel_s    = sel_q[SS-1];
  assign clk_s    = clk_q[SS-1];
  assign din_s    = din_q[SS-1];
  assign bit_rise = clk_s & ~clk_d & ~sel_s;
  assign sel_fall = ~sel_s & sel_d;
  assign sel_rise = sel_s & ~sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (sel_fall) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (bit_rise) begin
      sh_q <= {sh_q[MAX_BITS-2:0], din_s};
      if (cnt_q != CNT_W'(CNT_SAT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frame_end  = sel_rise;
  assign frame_len  = cnt_q;
  assign frame_bits = sh_q;

  p_cnt_saturates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_SAT));

  p_cnt_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |=> cnt_q == '0);
endmodule

// File: rtl/serial_frame_decode.sv
module serial_frame_decode
  import serial_cmd_pkg::*;
#(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned MEM_AW = 14,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  frame_len,
  input  logic [23:0]       frame_bits,
  input  logic [ID_W-1:0]   target_q,
  input  logic [ID_W-1:0]   self_id,
  output logic              emit,
  output cmd_kind_e         kind,
  output logic              is_read,
  output logic              is_global,
  output logic [MEM_AW-1:0] addr,
  output logic [7:0]        data,
  output logic              tgt_load,
  output logic [ID_W-1:0]   tgt_load_val,
  output logic              tgt_inc
);
  logic len_byte, len_reg, len_mem;
  logic reg_ok, local_hit, unused_bit;

  assign len_byte  = frame_end && (frame_len == CNT_W'(LEN_BYTE));
  assign len_reg   = frame_end && (frame_len == CNT_W'(LEN_REG));
  assign len_mem   = frame_end && (frame_len == CNT_W'(LEN_MEM));
  assign reg_ok    = len_reg && !frame_bits[12];
  assign local_hit = (target_q == self_id);
  assign unused_bit = frame_bits[22];

  always_comb begin
    emit      = 1'b0;
    kind      = CMD_INDIRECT;
    is_read   = 1'b0;
    is_global = 1'b0;
    addr      = '0;
    data      = frame_bits[7:0];
    if (len_byte) begin
      emit = 1'b1;
    end else if (reg_ok) begin
      kind      = CMD_REGISTER;
      is_read   = frame_bits[15];
      is_global = frame_bits[13];
      addr      = MEM_AW'(frame_bits[11:8]);
      emit      = frame_bits[13] | local_hit;
    end else if (len_mem) begin
      kind    = CMD_MEMORY;
      is_read = frame_bits[23];
      addr    = frame_bits[8 +: MEM_AW];
      emit    = 1'b1;
    end
  end

  assign tgt_load     = reg_ok && frame_bits[13] && !frame_bits[15]
                        && (frame_bits[11:8] == TARGET_REG_INDEX);
  assign tgt_load_val = ID_W'(frame_bits[7:0]);
  assign tgt_inc      = reg_ok && frame_bits[14];
endmodule

// File: rtl/serial_target_reg.sv
module serial_target_reg #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] load_val,
  input  logic            inc,
  output logic [ID_W-1:0] q
);
  logic [ID_W-1:0] base;

  assign base = load ? load_val : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (load | inc) q <= base + ID_W'(inc);
  end

  p_tgt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> q == $past(q) + 1'b1);

  p_tgt_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !inc) |=> q == $past(load_val));

  p_tgt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(q));
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
  import serial_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ID_W        = 8,
  parameter int unsigned MEM_AW      = 14,
  localparam int unsigned MAX_BITS   = LEN_MEM,
  localparam int unsigned CNT_W      = $clog2(MAX_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic [ID_W-1:0]   self_id,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic              cmd_read,
  output logic              cmd_global,
  output logic [MEM_AW-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic [ID_W-1:0]   target_addr
);
  logic                frame_end;
  logic [CNT_W-1:0]    frame_len;
  logic [MAX_BITS-1:0] frame_bits;
  logic                emit, d_read, d_global, tgt_load, tgt_inc, push;
  cmd_kind_e           d_kind;
  logic [MEM_AW-1:0]   d_addr;
  logic [7:0]          d_data;
  logic [ID_W-1:0]     tgt_load_val;

  serial_frame_rx #(.SYNC_STAGES(SYNC_STAGES), .MAX_BITS(MAX_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel_n_i(ser_sel_n), .sclk_i(ser_clk),
    .din_i(ser_din), .frame_end(frame_end), .frame_len(frame_len),
    .frame_bits(frame_bits)
  );

  serial_frame_decode #(.ID_W(ID_W), .MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_dec (
    .frame_end(frame_end), .frame_len(frame_len), .frame_bits(frame_bits),
    .target_q(target_addr), .self_id(self_id), .emit(emit), .kind(d_kind),
    .is_read(d_read), .is_global(d_global), .addr(d_addr), .data(d_data),
    .tgt_load(tgt_load), .tgt_load_val(tgt_load_val), .tgt_inc(tgt_inc)
  );

  serial_target_reg #(.ID_W(ID_W)) u_tgt (
    .clk(clk), .rst_n(rst_n), .load(tgt_load), .load_val(tgt_load_val),
    .inc(tgt_inc), .q(target_addr)
  );

  assign push = emit && (!cmd_valid || cmd_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      cmd_kind   <= 2'd0;
      cmd_read   <= 1'b0;
      cmd_global <= 1'b0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
    end else if (push) begin
      cmd_valid  <= 1'b1;
      cmd_kind   <= d_kind;
      cmd_read   <= d_read;
      cmd_global <= d_global;
      cmd_addr   <= d_addr;
      cmd_data   <= d_data;
    end else if (cmd_ready) begin
      cmd_valid  <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_kind)
      && $stable(cmd_addr) && $stable(cmd_data) && $stable(cmd_read)
      && $stable(cmd_global));

  p_len_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (frame_len == CNT_W'(LEN_BYTE) || frame_len == CNT_W'(LEN_REG)
              || frame_len == CNT_W'(LEN_MEM)));

  p_tgt_needs_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(target_addr));

  p_local_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && d_kind == CMD_REGISTER && !d_global) |-> target_addr == self_id);
endmodule

// File: tb/serial_cmd_decoder_test.sv
module serial_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0, ready = 1'b0;
  logic [7:0] self_id = 8'd3;
  logic valid, rd, glob;
  logic [1:0] kind;
  logic [13:0] addr;
  logic [7:0] data, tgt;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  serial_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sclk),
    .ser_din(sdin), .self_id(self_id), .cmd_valid(valid), .cmd_ready(ready),
    .cmd_kind(kind), .cmd_read(rd), .cmd_global(glob), .cmd_addr(addr),
    .cmd_data(data), .target_addr(tgt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    @(negedge clk);
    sel_n = 1'b0;
    wait_clk(3);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = v[i];
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
      sclk = 1'b0;
    end
    wait_clk(3);
    sel_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic expect_cmd(input logic [1:0] k, input logic r, input logic g,
                            input logic [13:0] a, input logic [7:0] d,
                            input string tag);
    chk(valid === 1'b1, {tag, " valid"}, 32'(valid), 1);
    chk(kind === k, {tag, " kind"}, 32'(kind), 32'(k));
    chk(rd === r, {tag, " read"}, 32'(rd), 32'(r));
    chk(glob === g, {tag, " global"}, 32'(glob), 32'(g));
    chk(addr === a, {tag, " addr"}, 32'(addr), 32'(a));
    chk(data === d, {tag, " data"}, 32'(data), 32'(d));
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    @(negedge clk);
    chk(valid === 1'b0, {tag, " drained"}, 32'(valid), 0);
  endtask

  task automatic expect_none(input string tag);
    chk(valid === 1'b0, {tag, " no command"}, 32'(valid), 0);
  endtask

  task automatic expect_tgt(input logic [7:0] e, input string tag);
    chk(tgt === e, {tag, " target"}, 32'(tgt), 32'(e));
  endtask

  // 16-bit frame builder: rd, autoinc, global, reserved, index, data
  function automatic logic [31:0] rf(input logic r, input logic ai,
      input logic g, input logic res, input logic [3:0] idx,
      input logic [7:0] d);
    return {16'd0, r, ai, g, res, idx, d};
  endfunction

  task automatic t_reset();
    chk(valid === 1'b0, "R1 valid after reset", 32'(valid), 0);
    expect_tgt(8'h00, "R1");
  endtask

  task automatic t_indirect();
    send(32'hA5, 8);
    expect_cmd(2'd0, 1'b0, 1'b0, 14'd0, 8'hA5, "R9 R3 byte A5");
    send(32'h01, 8);
    expect_cmd(2'd0, 1'b0, 1'b0, 14'd0, 8'h01, "R3 byte 01");
  endtask

  task automatic t_memory();
    send({8'd0, 1'b1, 1'b0, 14'h2ABC, 8'h3C}, 24);
    expect_cmd(2'd2, 1'b1, 1'b0, 14'h2ABC, 8'h3C, "R4 read");
    send({8'd0, 1'b0, 1'b1, 14'h1543, 8'hC3}, 24);
    expect_cmd(2'd2, 1'b0, 1'b0, 14'h1543, 8'hC3, "R4 write ignored bit");
  endtask

  task automatic t_register();
    send(rf(1'b0, 1'b0, 1'b1, 1'b0, 4'd8, 8'h05), 16);
    expect_cmd(2'd1, 1'b0, 1'b1, 14'd8, 8'h05, "R5 R6 global write");
    expect_tgt(8'h05, "R7 load");
    send(rf(1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 8'h77), 16);
    expect_none("R6 local miss");
    expect_tgt(8'h05, "R6 miss keeps target");
    send(rf(1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 8'h00), 16);
    expect_none("R8 miss with autoinc");
    expect_tgt(8'h06, "R8 inc on miss");
    send(rf(1'b0, 1'b0, 1'b1, 1'b0, 4'd8, 8'h03), 16);
    expect_cmd(2'd1, 1'b0, 1'b1, 14'd8, 8'h03, "R7 reload");
    send(rf(1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 8'h9A), 16);
    expect_cmd(2'd1, 1'b1, 1'b0, 14'd2, 8'h9A, "R6 local hit");
    send(rf(1'b0, 1'b1, 1'b1, 1'b1, 4'd8, 8'h40), 16);
    expect_none("R5 reserved bit");
    expect_tgt(8'h03, "R5 reserved no change");
    send(rf(1'b1, 1'b0, 1'b1, 1'b0, 4'd8, 8'h55), 16);
    expect_cmd(2'd1, 1'b1, 1'b1, 14'd8, 8'h55, "R7 global read");
    expect_tgt(8'h03, "R7 read no load");
    send(rf(1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 8'hFF), 16);
    expect_cmd(2'd1, 1'b0, 1'b1, 14'd8, 8'hFF, "R8 load with inc");
    expect_tgt(8'h00, "R8 load then wrap");
  endtask

  task automatic t_bad_len();
    send(32'h7F, 7);
    expect_none("R2 7 bits");
    send(32'h1FF, 9);
    expect_none("R2 9 bits");
    send({15'd0, 17'h0C0FF}, 17);
    expect_none("R2 17 bits");
    send(32'h3FFF_FFFF, 30);
    expect_none("R2 30 bits");
    send({16'd0, rf(1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 8'h22)} >> 0, 15);
    expect_none("R2 15 bits");
    expect_tgt(8'h00, "R2 bad lengths keep target");
  endtask

  task automatic t_backpressure();
    send(32'h11, 8);
    send(rf(1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 8'h20), 16);
    expect_tgt(8'h21, "R10 target still updated");
    expect_cmd(2'd0, 1'b0, 1'b0, 14'd0, 8'h11, "R10 first held");
    expect_none("R10 second dropped");
  endtask

  initial begin
    wait_clk(100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_indirect();
    t_memory();
    t_register();
    t_bad_len();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule